// File: doc/BRIEF.md
# Inter-Processor Doorbell Signal Router

This block gathers one-cycle doorbell pulses from a set of remote clients, each able to raise any of several signals. It records them in pending bits and drives one level-high interrupt to the local processor. The interrupt stays high while any pending signal is also unmasked. Software handles the interrupt in a loop. It reads a register that reports the packed identifier of the next enabled pending signal, clears that signal, and repeats until the register returns all-ones.

Every register write carries the same packed identifier: the client number in bits 31:16 and the signal number in bits 15:0. A write to the doorbell register sends a one-cycle outbound pulse, with that client and signal number, toward a remote client. Other registers mask, unmask and clear individual inbound signals. A soft reset register wipes all pending and enable state. Client and signal counts are parameters. Inbound bit `c*NUM_SIG + s` of `in_pulse` belongs to client `c`, signal `s`.

Top module: `sigroute_regs`

## Requirements
- R1: After reset every pending bit and every enable is zero, `irq` is low, no outbound pulse is active, and a read of offset 0x10 returns 0xFFFFFFFF.
- R2: A write to offset 0x0C with an in-range identifier makes `out_valid` high for exactly the next clock cycle, with `out_client` = bits 31:16 and `out_signal` = bits 15:0 of the written word.
- R3: A read of offset 0x10 returns `{client[15:0], signal[15:0]}` of the enabled pending signal with the lowest packed value, or 0xFFFFFFFF if there is none. A read of any other offset returns zero.
- R4: A write to offset 0x14 unmasks the named signal and a write to offset 0x18 masks it. Both take effect from the next cycle.
- R5: A write to offset 0x1C clears the pending bit of the named signal.
- R6: A write to offset 0x38 with bit 0 set clears all pending bits and all enables. It also overrides inbound pulses that arrive in the same cycle.
- R7: `irq` is high exactly when at least one signal is both pending and enabled.
- R8: An inbound pulse sets the signal's pending bit even while the signal is masked. Unmasking it later raises `irq`.
- R9: When a clear write and an inbound pulse hit the same signal in the same cycle, the signal stays pending.
- R10: A write whose client is at least `NUM_CLIENT`, or whose signal is at least `NUM_SIG`, changes no state and produces no outbound pulse.
- R11: Reading offset 0x10 changes no state. Repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (packed identifier) |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| in_pulse | input | NUM_CLIENT*NUM_SIG | Inbound doorbell pulses, one bit per client/signal |
| out_valid | output | 1 | One-cycle outbound doorbell strobe |
| out_client | output | 16 | Target client of the outbound doorbell |
| out_signal | output | 16 | Target signal of the outbound doorbell |
| irq | output | 1 | Level-high summary interrupt |

## Verification
The bench builds the block with three clients and five signals. Because these counts are not powers of two, signal numbers 5 to 7 and client 3 fall outside the configured range while remaining cheap to generate. Such identifiers would alias onto real bits if the range check were missing. The small array of 15 signals also lets random pulses and mask changes produce frequent collisions: several enabled signals pending at once, which exercises the lowest-identifier ordering, and clear/pulse coincidences on the same bit.

// File: rtl/sigroute_regs.sv
module sigroute_regs #(
  parameter int NUM_CLIENT = 3,
  parameter int NUM_SIG    = 5,
  parameter int ADDR_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_CLIENT*NUM_SIG-1:0] in_pulse,
  output logic                          out_valid,
  output logic [15:0]                   out_client,
  output logic [15:0]                   out_signal,
  output logic                          irq
);
  localparam int N = NUM_CLIENT * NUM_SIG;
  localparam logic [ADDR_W-1:0] OFS_RING  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_NEXT  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_UNMSK = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFS_MSK   = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFS_CLR   = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] OFS_WIPE  = ADDR_W'('h38);

  logic [N-1:0] pend_q, en_q, hit, sel;
  logic [15:0]  wr_cli, wr_sig;
  logic         id_ok, wipe;

  assign wr_cli = bus_wdata[31:16];
  assign wr_sig = bus_wdata[15:0];
  assign id_ok  = ({16'd0, wr_cli} < 32'(NUM_CLIENT)) && ({16'd0, wr_sig} < 32'(NUM_SIG));
  assign wipe   = bus_we && bus_addr == OFS_WIPE && bus_wdata[0];
  assign hit    = pend_q & en_q;
  assign irq    = |hit;

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int C = i / NUM_SIG;
    localparam int S = i % NUM_SIG;
    assign sel[i] = bus_we && id_ok && wr_cli == 16'(C) && wr_sig == 16'(S);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else if (wipe) begin
        pend_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        pend_q[i] <= in_pulse[i] | (pend_q[i] & ~(sel[i] && bus_addr == OFS_CLR));
        if (sel[i] && bus_addr == OFS_UNMSK) en_q[i] <= 1'b1;
        else if (sel[i] && bus_addr == OFS_MSK) en_q[i] <= 1'b0;
      end
  end

  always_comb begin
    logic found;
    logic [31:0] nxt;
    found = 1'b0;
    nxt   = '1;
    for (int c = 0; c < NUM_CLIENT; c++)
      for (int s = 0; s < NUM_SIG; s++)
        if (!found && hit[c*NUM_SIG+s]) begin
          nxt   = {16'(c), 16'(s)};
          found = 1'b1;
        end
    bus_rdata = (bus_addr == OFS_NEXT) ? nxt : 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_client <= '0;
      out_signal <= '0;
    end else begin
      out_valid <= bus_we && bus_addr == OFS_RING && id_ok;
      if (bus_we && bus_addr == OFS_RING && id_ok) begin
        out_client <= wr_cli;
        out_signal <= wr_sig;
      end
    end
endmodule

// File: rtl/sigroute_regs_chk.sv
module sigroute_regs_chk #(
  parameter int N      = 15,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [N-1:0]      in_pulse,
  input logic [N-1:0]      pend,
  input logic              out_valid,
  input logic              irq
);
  AST_RING_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(bus_we && bus_addr == ADDR_W'('h0C))); // R2

  AST_NEXT_WHEN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h10) && irq) |-> bus_rdata != 32'hFFFF_FFFF); // R7

  AST_NEXT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h10) && !irq) |-> bus_rdata == 32'hFFFF_FFFF); // R3

  AST_WIPE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h38) && bus_wdata[0]) |=> (!irq && pend == '0)); // R6

  AST_PULSE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_we && bus_addr == ADDR_W'('h38) && bus_wdata[0]) && in_pulse != '0)
      |=> ((pend & $past(in_pulse)) == $past(in_pulse))); // R8
endmodule

bind sigroute_regs sigroute_regs_chk #(.N(NUM_CLIENT*NUM_SIG), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_pulse(in_pulse),
  .pend(pend_q), .out_valid(out_valid), .irq(irq));

// File: tb/sigroute_regs_tb.sv
module sigroute_regs_tb;
  localparam int NC = 3;
  localparam int NS = 5;
  localparam int N  = NC * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = 8'h10;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  in_pulse = '0;
  logic          out_valid, irq;
  logic [15:0]   out_client, out_signal;

  int tests = 0, fails = 0;
  logic [N-1:0] m_pend = '0, m_en = '0;
  logic         m_ov = 1'b0;
  logic [15:0]  m_oc = '0, m_os = '0;

  always #10 clk = ~clk;

  sigroute_regs #(.NUM_CLIENT(NC), .NUM_SIG(NS), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_pulse(in_pulse),
    .out_valid(out_valid), .out_client(out_client), .out_signal(out_signal),
    .irq(irq));

  function automatic logic [31:0] exp_next();
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i]) return {16'(i / NS), 16'(i % NS)};
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] pid(int c, int s);
    return {16'(c), 16'(s)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, |(m_pend & m_en)});
    chk({tag, " next"}, bus_rdata, exp_next());
    chk({tag, " out_valid"}, {31'd0, out_valid}, {31'd0, m_ov});
    if (m_ov) chk({tag, " out_id"}, {out_client, out_signal}, {m_oc, m_os});
  endtask

  task automatic step(logic we, logic [7:0] a, logic [31:0] d, logic [N-1:0] p, string tag);
    logic [15:0] c, s;
    logic ok;
    int idx;
    logic [N-1:0] np, ne;
    bus_we = we; bus_addr = a; bus_wdata = d; in_pulse = p;
    c = d[31:16]; s = d[15:0];
    ok = (c < 16'(NC)) && (s < 16'(NS));
    idx = ok ? int'(c) * NS + int'(s) : 0;
    np = m_pend; ne = m_en;
    if (we && a == 8'h38 && d[0]) begin
      np = '0; ne = '0;
    end else begin
      if (we && ok && a == 8'h1C) np[idx] = 1'b0;
      np = np | p;
      if (we && ok && a == 8'h14) ne[idx] = 1'b1;
      if (we && ok && a == 8'h18) ne[idx] = 1'b0;
    end
    @(posedge clk);
    m_pend = np; m_en = ne;
    m_ov = we && ok && a == 8'h0C;
    if (m_ov) begin m_oc = c; m_os = s; end
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h10; in_pulse = '0;
    #1 check_all(tag);
  endtask

  function automatic logic [N-1:0] bitof(int c, int s);
    logic [N-1:0] v = '0;
    v[c*NS+s] = 1'b1;
    return v;
  endfunction

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    #1 check_all("R1 after release");

    step(0, 8'h10, 0, bitof(1, 2), "R8 pulse masked");
    step(1, 8'h14, pid(1, 2), '0, "R8 unmask pending R4");
    chk("R7 irq high", {31'd0, irq}, 32'd1);
    chk("R3 next 1/2", bus_rdata, 32'h0001_0002);

    step(0, 8'h10, 0, bitof(0, 4) | bitof(2, 0), "R3 pulses");
    step(1, 8'h14, pid(2, 0), '0, "R4 unmask 2/0");
    step(1, 8'h14, pid(0, 4), '0, "R4 unmask 0/4");
    chk("R3 lowest first", bus_rdata, 32'h0000_0004);
    step(0, 8'h10, 0, '0, "R11 read 1");
    step(0, 8'h10, 0, '0, "R11 read 2");
    chk("R11 stable read", bus_rdata, 32'h0000_0004);

    step(1, 8'h1C, pid(0, 4), bitof(0, 4), "R9 clear vs pulse");
    chk("R9 still pending", bus_rdata, 32'h0000_0004);
    step(1, 8'h1C, pid(0, 4), '0, "R5 clear");
    chk("R5 cleared", bus_rdata, 32'h0001_0002);
    step(1, 8'h18, pid(1, 2), '0, "R4 mask");
    chk("R4 masked", bus_rdata, 32'h0002_0000);

    step(0, 8'h10, 0, bitof(1, 0), "R10 prep");
    step(1, 8'h14, pid(0, 5), '0, "R10 enable sig out of range");
    step(1, 8'h14, pid(3, 0), '0, "R10 enable client out of range");
    chk("R10 no alias", bus_rdata, 32'h0002_0000);
    step(1, 8'h1C, pid(0, 10), '0, "R10 clear out of range");
    chk("R10 clear ignored", bus_rdata, 32'h0002_0000);
    step(1, 8'h0C, pid(0, 6), '0, "R10 ring out of range");
    chk("R10 no ring", {31'd0, out_valid}, 32'd0);

    step(1, 8'h0C, pid(2, 3), '0, "R2 ring");
    chk("R2 ring fields", {out_client, out_signal}, 32'h0002_0003);
    step(0, 8'h10, 0, '0, "R2 one cycle");
    chk("R2 strobe dropped", {31'd0, out_valid}, 32'd0);

    bus_addr = 8'h14;
    #1 chk("R3 other offset reads zero", bus_rdata, 32'd0);
    bus_addr = 8'h10;

    step(1, 8'h38, 32'd1, bitof(0, 0) | bitof(2, 4), "R6 wipe with pulses");
    chk("R6 all idle", bus_rdata, 32'hFFFF_FFFF);
    step(0, 8'h10, 0, bitof(1, 1), "R6 prep");
    step(1, 8'h14, pid(1, 1), '0, "R6 enables wiped R8");
    chk("R6 pend survives only new", bus_rdata, 32'h0001_0001);

    for (int k = 0; k < 800; k++) begin
      logic [7:0] a;
      logic [31:0] d;
      logic [N-1:0] p;
      int op;
      op = $urandom_range(0, 15);
      case (op)
        0, 1:    a = 8'h0C;
        2, 3, 4: a = 8'h14;
        5, 6:    a = 8'h18;
        7, 8, 9: a = 8'h1C;
        10:      a = 8'h38;
        default: a = 8'h10;
      endcase
      d = pid($urandom_range(0, 3), $urandom_range(0, 7));
      if (a == 8'h38) d = ($urandom_range(0, 3) == 0) ? 32'd1 : 32'd0;
      p = '0;
      for (int b = 0; b < N; b++) p[b] = ($urandom_range(0, 9) == 0);
      step(op < 11, a, d, p, "R3/R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule